// File: doc/BRIEF.md
# Prescaled 16-Bit Timer/Counter

This block is a timer channel that counts up through a full 16-bit range, built from a low byte and a high byte that software can write one at a time. Ticks come from a prescaler on the system clock. A two-bit speed selection picks one of three tick periods: 12 system clocks, 4 system clocks, or every system clock. Counting runs only while the run bit is set and the mode field selects 16-bit operation.

When the count wraps from all ones to zero, the block sets an overflow flag. An interrupt request goes out while that flag is set and both a local enable and a global enable are on. Counting goes on from zero after a wrap. To get a fixed period, software writes the count bytes again after each overflow. A preload of 65536-N puts N ticks between overflows.

Software reaches four byte-wide registers through a small write/read port. The read data follows the address combinationally.

Top module: `prescaled_timer16`

## Requirements
- R1: After reset, all four registers read 0x00 and irq is low. A zero speed selection means one tick every 12 system clocks.
- R2: The register map is: address 0 is the count low byte, address 1 is the count high byte, address 2 is control, and address 3 is configuration. Control holds run (bit 0), overflow flag (bit 1), local enable (bit 2) and global enable (bit 3). Configuration holds mode (bits 1:0), fast select (bit 4) and undivided select (bit 5).
- R3: The count advances by one per tick, carrying from the low byte into the high byte. It advances only while run is 1 and mode is 01. Otherwise it holds its value.
- R4: The tick period depends on two bits. With fast=0 it is 12 clocks. With fast=1 and undivided=0 it is 4 clocks. With fast=1 and undivided=1 it is 1 clock. The first increment lands that many clock edges after the edge that writes run=1.
- R5: Clearing run (or leaving mode 01) resets the prescaler. A restart therefore always waits one full tick period before the first increment.
- R6: A wrap from 0xFFFF to 0x0000 sets the overflow flag, whatever the enables hold. Counting then goes on from 0x0000.
- R7: irq is high exactly while the overflow flag, the local enable and the global enable are all 1.
- R8: The overflow flag clears on an irq_ack pulse or on a control write with bit 1 at 0. A control write with bit 1 at 1 leaves the flag unchanged. A wrap in the same cycle wins over either clear.
- R9: A write to either count byte takes priority over a tick in the same cycle. The written byte takes the new data, the other byte keeps its value, and no increment happens that cycle.
- R10: Preloading 65536-N and starting the timer sets the overflow flag after exactly N tick periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq_ack | input | 1 | Interrupt acknowledge, clears the overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
Directed runs cover each of the three tick speeds, using short preloads next to 0xFFFF. Sampling one edge before and one edge on the expected increment or wrap shows whether a prescale period is off by one cycle. A stop partway through a period, followed by a restart, shows whether the prescaler really clears or resumes from where it stopped. A byte write that lands on a tick at the undivided speed separates write priority from write-then-increment. Random preload distances at random speeds then confirm the overflow interval of N tick periods.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam logic [1:0] ADDR_CNT_LO = 2'd0;
  localparam logic [1:0] ADDR_CNT_HI = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
  localparam logic [1:0] ADDR_CFG    = 2'd3;

  localparam logic [1:0] MODE_FULL16 = 2'b01;

  typedef enum logic [1:0] {
    TICK_SLOW = 2'd0,
    TICK_FAST = 2'd1,
    TICK_EACH = 2'd2
  } tick_sel_e;
endpackage

// File: rtl/ptmr_rst_sync.sv
module ptmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale
  import ptmr_pkg::*;
#(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  tick_sel_e sel,
  output logic      tick,
  output logic      pre_idle
);
  localparam int PW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [PW-1:0] SLOW_LIM = PW'(SLOW_DIV - 1);
  localparam logic [PW-1:0] FAST_LIM = PW'(FAST_DIV - 1);

  logic [PW-1:0] pre_q, pre_d, limit;

  always_comb begin
    case (sel)
      TICK_FAST: limit = FAST_LIM;
      TICK_EACH: limit = '0;
      default:   limit = SLOW_LIM;
    endcase
  end

  assign tick = enable && (pre_q >= limit);

  always_comb begin
    if (!enable || tick) pre_d = '0;
    else                 pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign pre_idle = (pre_q == '0);
endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
  parameter int CW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW/BW-1:0] byte_we,
  input  logic [BW-1:0] wdata,
  output logic [CW-1:0] count,
  output logic          wrap
);
  localparam int NB = CW / BW;

  logic [CW-1:0] cnt_q, cnt_d, merged;
  logic          any_we;

  assign any_we = |byte_we;

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_byte
      assign merged[b*BW +: BW] = byte_we[b] ? wdata : cnt_q[b*BW +: BW];
    end
  endgenerate

  always_comb begin
    if (any_we)    cnt_d = merged;
    else if (tick) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign wrap  = tick && !any_we && (&cnt_q);
  assign count = cnt_q;
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic          cfg_we,
  input  logic [BW-1:0] wdata,
  input  logic          wrap,
  input  logic          ack,
  output logic          run,
  output logic          flag,
  output logic          ie,
  output logic          gie,
  output logic [1:0]    mode,
  output logic          fast,
  output logic          undiv
);
  logic       run_q, run_d, flag_q, flag_d, ie_q, ie_d, gie_q, gie_d;
  logic [1:0] mode_q, mode_d;
  logic       fast_q, fast_d, undiv_q, undiv_d;

  always_comb begin
    run_d   = run_q;
    ie_d    = ie_q;
    gie_d   = gie_q;
    mode_d  = mode_q;
    fast_d  = fast_q;
    undiv_d = undiv_q;
    flag_d  = flag_q;
    if (ctrl_we) begin
      run_d = wdata[0];
      ie_d  = wdata[2];
      gie_d = wdata[3];
      if (!wdata[1]) flag_d = 1'b0;
    end
    if (cfg_we) begin
      mode_d  = wdata[1:0];
      fast_d  = wdata[4];
      undiv_d = wdata[5];
    end
    if (ack)  flag_d = 1'b0;
    if (wrap) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      flag_q  <= 1'b0;
      ie_q    <= 1'b0;
      gie_q   <= 1'b0;
      mode_q  <= 2'b00;
      fast_q  <= 1'b0;
      undiv_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      flag_q  <= flag_d;
      ie_q    <= ie_d;
      gie_q   <= gie_d;
      mode_q  <= mode_d;
      fast_q  <= fast_d;
      undiv_q <= undiv_d;
    end
  end

  assign run   = run_q;
  assign flag  = flag_q;
  assign ie    = ie_q;
  assign gie   = gie_q;
  assign mode  = mode_q;
  assign fast  = fast_q;
  assign undiv = undiv_q;
endmodule

// File: rtl/prescaled_timer16.sv
module prescaled_timer16
  import ptmr_pkg::*;
#(
  parameter int COUNT_W  = 16,
  parameter int BYTE_W   = 8,
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              irq_ack,
  output logic              irq
);
  localparam int NB = COUNT_W / BYTE_W;

  logic               rst_sync_n;
  logic               run, flag, ie, gie, fast, undiv;
  logic [1:0]         mode;
  logic               count_en, tick, wrap, pre_idle;
  logic [NB-1:0]      byte_we;
  logic [COUNT_W-1:0] count;
  tick_sel_e          sel;

  ptmr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_bwe
      assign byte_we[b] = reg_we && (reg_addr == 2'(b));
    end
  endgenerate

  always_comb begin
    if (!fast)      sel = TICK_SLOW;
    else if (undiv) sel = TICK_EACH;
    else            sel = TICK_FAST;
  end

  assign count_en = run && (mode == MODE_FULL16);

  ptmr_prescale #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .enable(count_en), .sel(sel),
    .tick(tick), .pre_idle(pre_idle)
  );

  ptmr_count #(.CW(COUNT_W), .BW(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .byte_we(byte_we),
    .wdata(reg_wdata), .count(count), .wrap(wrap)
  );

  ptmr_regs #(.BW(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .ctrl_we(reg_we && (reg_addr == ADDR_CTRL)),
    .cfg_we(reg_we && (reg_addr == ADDR_CFG)),
    .wdata(reg_wdata), .wrap(wrap), .ack(irq_ack),
    .run(run), .flag(flag), .ie(ie), .gie(gie),
    .mode(mode), .fast(fast), .undiv(undiv)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CNT_LO: reg_rdata = count[BYTE_W-1:0];
      ADDR_CNT_HI: reg_rdata = count[2*BYTE_W-1:BYTE_W];
      ADDR_CTRL:   reg_rdata[3:0] = {gie, ie, flag, run};
      default:     reg_rdata[5:0] = {undiv, fast, 2'b00, mode};
    endcase
  end

  assign irq = flag && ie && gie;
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker #(
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq,
  input logic               irq_ack,
  input logic               flag,
  input logic               ie,
  input logic               gie,
  input logic               count_en,
  input logic               tick,
  input logic               wrap,
  input logic               pre_idle,
  input logic [1:0]         byte_we,
  input logic [7:0]         wdata,
  input logic [COUNT_W-1:0] count
);
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && ie && gie));

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && byte_we == 2'b00) |=> $stable(count));

  assert_prescale_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |=> pre_idle);

  assert_wrap_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (flag && count == '0));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !wrap) |=> !flag);

  assert_low_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we[0] |=> (count[7:0] == $past(wdata) && count[15:8] == $past(count[15:8])));

  assert_tick_only_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> count_en);
endmodule

bind prescaled_timer16 ptmr_checker #(.COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .irq(irq), .irq_ack(irq_ack),
  .flag(flag), .ie(ie), .gie(gie), .count_en(count_en), .tick(tick),
  .wrap(wrap), .pre_idle(pre_idle), .byte_we(byte_we[1:0]),
  .wdata(reg_wdata), .count(count[15:0])
);

// File: tb/prescaled_timer16_test.sv
module prescaled_timer16_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_ack = 1'b0;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  prescaled_timer16 uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq(irq)
  );

  function automatic int div_of(input int sel);
    if (sel == 0) return 12;
    if (sel == 1) return 4;
    return 1;
  endfunction

  function automatic logic [7:0] cfg_of(input int sel);
    if (sel == 0) return 8'h01;
    if (sel == 1) return 8'h11;
    return 8'h31;
  endfunction

  function automatic logic [15:0] preload_for(input int n);
    return 16'(65536 - n);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic rd_cnt(output logic [15:0] c);
    logic [7:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    c = {hi, lo};
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0]  r;
    logic [15:0] c, c0;
    int          seed;
    seed = int'($urandom(32'h5eed));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      check("R1 reset register", {8'h00, r}, 16'h0000);
    end
    check("R1 reset irq", {15'd0, irq}, 16'd0);

    // R2/R4/R10: default divide-by-12 with preload 0xFFFE
    wr(2'd3, 8'h01);
    wr(2'd0, 8'hFE);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h01);
    wait_neg(11); rd_cnt(c); check("R4 slow before tick", c, 16'hFFFE);
    wait_neg(1);  rd_cnt(c); check("R4 slow first tick", c, 16'hFFFF);
    wait_neg(11); rd(2'd2, r); check("R10 flag not yet", {15'd0, r[1]}, 16'd0);
    wait_neg(1);  rd_cnt(c); check("R6 wrap to zero", c, 16'h0000);
    rd(2'd2, r); check("R6 flag set regardless of enables", {8'h00, r}, 16'h0003);
    check("R7 irq low without enables", {15'd0, irq}, 16'd0);

    // R6: counting continues past zero
    wait_neg(12); rd_cnt(c); check("R6 continue after wrap", c, 16'h0001);

    // R7: enable gating
    wr(2'd2, 8'h07); // run, keep flag, local only
    check("R7 irq low without global", {15'd0, irq}, 16'd0);
    wr(2'd2, 8'h0F);
    check("R7 irq high with both", {15'd0, irq}, 16'd1);
    // R8: ack clears
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    rd(2'd2, r); check("R8 ack clears flag", {15'd0, r[1]}, 16'd0);
    check("R8 irq low after ack", {15'd0, irq}, 16'd0);
    // R8: writing 1 to flag has no effect
    wr(2'd2, 8'h03);
    rd(2'd2, r); check("R8 write one ignored", {15'd0, r[1]}, 16'd0);

    // R3: stopped counter holds
    wr(2'd2, 8'h00);
    rd_cnt(c0);
    wait_neg(30);
    rd_cnt(c); check("R3 hold when stopped", c, c0);

    // R5: prescaler restart
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wr(2'd2, 8'h01);
    wait_neg(5);
    wr(2'd2, 8'h00);
    rd_cnt(c); check("R5 no tick before stop", c, 16'h0000);
    wr(2'd2, 8'h01);
    wait_neg(11); rd_cnt(c); check("R5 full period after restart", c, 16'h0000);
    wait_neg(1);  rd_cnt(c); check("R5 tick after restart", c, 16'h0001);
    wr(2'd2, 8'h00);

    // R3: mode other than 01 does not count
    wr(2'd3, 8'h00);
    rd_cnt(c0);
    wr(2'd2, 8'h01);
    wait_neg(30);
    rd_cnt(c); check("R3 wrong mode holds", c, c0);
    wr(2'd2, 8'h00);

    // R4: divide by 4
    wr(2'd3, 8'h11);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wr(2'd2, 8'h01);
    wait_neg(3); rd_cnt(c); check("R4 fast before tick", c, 16'h0000);
    wait_neg(1); rd_cnt(c); check("R4 fast tick", c, 16'h0001);
    wr(2'd2, 8'h00);

    // R4/R9: undivided, write beats tick
    wr(2'd3, 8'h31);
    wr(2'd0, 8'h00); wr(2'd1, 8'h01);
    wr(2'd2, 8'h01);
    wait_neg(3); rd_cnt(c); check("R4 undivided count", c, 16'h0103);
    wr(2'd0, 8'h10);
    rd_cnt(c); check("R9 write beats tick", c, 16'h0110);
    wait_neg(1); rd_cnt(c); check("R9 counting resumes", c, 16'h0111);
    wr(2'd2, 8'h00);

    // R10: random preload distances and speeds
    for (int i = 0; i < 20; i++) begin
      int sel, n;
      logic [15:0] p;
      sel = int'($urandom % 3);
      n   = 1 + int'($urandom % 6);
      p   = preload_for(n);
      wr(2'd3, cfg_of(sel));
      wr(2'd0, p[7:0]);
      wr(2'd1, p[15:8]);
      wr(2'd2, 8'h01);
      wait_neg(n * div_of(sel) - 1);
      rd(2'd2, r); check("R10 random no early flag", {15'd0, r[1]}, 16'd0);
      wait_neg(1);
      rd(2'd2, r); check("R10 random flag on time", {15'd0, r[1]}, 16'd1);
      rd_cnt(c);   check("R10 random wrapped count", c, 16'h0000);
      wr(2'd2, 8'h00);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule